// File: doc/BRIEF.md
# Out-of-Order Reservation Station Pool

This block is a shared pool of waiting slots placed between an in-order dispatch stage and a set of functional units. Each cycle, dispatch can hand over up to three operations. Each operation carries its target unit, a destination tag and two source operands. A source operand is either a ready value or a tag that names the result it is still waiting for. The pool snoops a single result broadcast bus. It captures any missing operand whose tag appears there.

Every unit has its own issue port. An entry goes to its unit as soon as both of its operands are present and the unit signals that it can accept work. Age plays no part in this. When several ready entries want the same unit, the entry in the lowest slot is chosen. An issued slot becomes free again on the following cycle. Dispatch stalls as a whole when the free slots cannot hold every lane requested. A flush empties the pool at once.

Top module: `rsp_pool`

## Requirements
- R1: After reset the pool is empty: no issue port is valid even with every unit free, and `disp_ready` is 1 for any request of up to three lanes.
- R2: Up to three lanes are accepted in one cycle when free slots suffice. Valid lanes take the free slots in ascending order: the lowest valid lane gets the lowest free slot. An entry whose operands are both ready is visible on its unit's issue port in the cycle after acceptance.
- R3: An entry is not issued while either operand is missing, and is not issued while its unit's `fu_free` bit is 0. It stays held until both conditions are met.
- R4: When `bc_valid` is 1 and `bc_tag` equals the tag of a missing operand of a held entry, that operand takes `bc_data` and becomes present. The entry can issue in the next cycle.
- R5: An operand dispatched as missing is captured as present, with `bc_data`, if a matching broadcast occurs in its dispatch cycle.
- R6: Entries issue without age order: a younger entry that is ready issues while an older entry for the same unit still waits.
- R7: At most one entry issues per unit per cycle, and the lowest-slot ready entry wins. Different units issue in the same cycle independently.
- R8: `disp_ready` is 0 when the free slots are fewer than the number of valid lanes. In that cycle no lane is written.
- R9: An entry issued in one cycle frees its slot, which can be accepted by dispatch in the next cycle.
- R10: `flush` empties every slot at the next edge. A dispatch presented in the flush cycle is discarded.
- R11: A broadcast whose tag matches an operand that is already present does not change that operand's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all slots |
| disp_valid | input | DISP_W | Per-lane dispatch request |
| disp_op | input | DISP_W x OP_W | Operation code per lane |
| disp_fu | input | DISP_W x FU_W | Target unit index per lane |
| disp_dst | input | DISP_W x TAG_W | Destination tag per lane |
| disp_a_tag | input | DISP_W x TAG_W | Source A producer tag |
| disp_a_data | input | DISP_W x DATA_W | Source A value |
| disp_a_vld | input | DISP_W | Source A present |
| disp_b_tag | input | DISP_W x TAG_W | Source B producer tag |
| disp_b_data | input | DISP_W x DATA_W | Source B value |
| disp_b_vld | input | DISP_W | Source B present |
| disp_ready | output | 1 | All valid lanes fit and are accepted |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Broadcast producer tag |
| bc_data | input | DATA_W | Broadcast value |
| fu_free | input | N_FU | Unit can accept an operation |
| iss_valid | output | N_FU | Issue this cycle per unit |
| iss_op | output | N_FU x OP_W | Issued operation code |
| iss_dst | output | N_FU x TAG_W | Issued destination tag |
| iss_a | output | N_FU x DATA_W | Issued source A value |
| iss_b | output | N_FU x DATA_W | Issued source B value |

## Verification
The bench uses several stimulus patterns.

- **Ready operations on one unit** show the slot order and the limit of one issue per unit.
- **One operation for each unit** shows that the units issue in parallel.
- **A waiting operation followed by a ready one** separates operand-driven issue from age order.
- **Broadcasts aimed at held operands, at operands in their dispatch cycle, and at operands already present** separate wakeup, same-cycle capture and the rule that a present value is kept.
- **Filling the pool to its limit with partial and full requests** shows the all-or-nothing stall and the one-cycle reuse of a slot after issue. Marked destination tags on the stalled lanes prove that nothing from them was written.
- **A flush that arrives with a dispatch** shows that both the held entries and the new lanes are dropped.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    localparam int TAG_W  = 6;
    localparam int DATA_W = 16;
    localparam int OP_W   = 5;
    localparam int N_FU   = 3;
    localparam int FU_W   = (N_FU > 1) ? $clog2(N_FU) : 1;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
        logic              vld;
    } opnd_t;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [FU_W-1:0]  fu;
        logic [TAG_W-1:0] dst;
        opnd_t            a;
        opnd_t            b;
    } slot_t;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } cdb_t;

    function automatic opnd_t snoop(opnd_t s, cdb_t bc);
        opnd_t r;
        r = s;
        if (!s.vld && bc.vld && (bc.tag == s.tag)) begin
            r.data = bc.data;
            r.vld  = 1'b1;
        end
        return r;
    endfunction

    function automatic logic slot_ready(slot_t s);
        return s.a.vld & s.b.vld;
    endfunction
endpackage

// File: rtl/rsp_entry.sv
module rsp_entry
    import rsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  wr_en,
    input  slot_t wr_slot,
    input  cdb_t  bc,
    input  logic  clr,
    output logic  busy,
    output slot_t slot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            slot <= '0;
        end else if (flush) begin
            busy <= 1'b0;
        end else if (wr_en) begin
            busy   <= 1'b1;
            slot   <= wr_slot;
            slot.a <= snoop(wr_slot.a, bc);
            slot.b <= snoop(wr_slot.b, bc);
        end else begin
            if (clr) busy <= 1'b0;
            slot.a <= snoop(slot.a, bc);
            slot.b <= snoop(slot.b, bc);
        end
    end

    a_r8_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !busy);
    a_r3_issue_ready: assert property (@(posedge clk) disable iff (rst)
        clr |-> (busy && slot.a.vld && slot.b.vld));
    a_r9_freed_after_issue: assert property (@(posedge clk) disable iff (rst)
        (clr && !flush) |=> !busy);
    a_r4_wakeup_a: assert property (@(posedge clk) disable iff (rst)
        (busy && !flush && !wr_en && !slot.a.vld && bc.vld && bc.tag == slot.a.tag)
        |=> (slot.a.vld && slot.a.data == $past(bc.data)));
    a_r4_wakeup_b: assert property (@(posedge clk) disable iff (rst)
        (busy && !flush && !wr_en && !slot.b.vld && bc.vld && bc.tag == slot.b.tag)
        |=> (slot.b.vld && slot.b.data == $past(bc.data)));
    a_r11_hold_a: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_en && slot.a.vld) |=> $stable(slot.a));
    a_r11_hold_b: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_en && slot.b.vld) |=> $stable(slot.b));
endmodule

// File: rtl/rsp_alloc.sv
module rsp_alloc #(
    parameter int N_ENT  = 20,
    parameter int DISP_W = 3,
    localparam int LANE_W = (DISP_W > 1) ? $clog2(DISP_W) : 1,
    localparam int CNT_W  = $clog2(N_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [N_ENT-1:0]  busy,
    input  logic [DISP_W-1:0] req,
    output logic              ready,
    output logic [N_ENT-1:0]  wr_en,
    output logic [LANE_W-1:0] lane_sel [N_ENT]
);
    logic [N_ENT-1:0] avail;
    logic [N_ENT-1:0] pick;
    logic             found;
    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] req_cnt;

    always_comb begin
        avail = ~busy;
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < N_ENT; i++) lane_sel[i] = '0;
        for (int j = 0; j < DISP_W; j++) begin
            found = 1'b0;
            if (req[j]) begin
                for (int i = 0; i < N_ENT; i++) begin
                    if (avail[i] && !found) begin
                        pick[i]     = 1'b1;
                        lane_sel[i] = LANE_W'(j);
                        avail[i]    = 1'b0;
                        found       = 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < N_ENT; i++)
            if (!busy[i]) free_cnt = free_cnt + CNT_W'(1);
        req_cnt = '0;
        for (int j = 0; j < DISP_W; j++)
            if (req[j]) req_cnt = req_cnt + CNT_W'(1);
    end

    assign ready = (free_cnt >= req_cnt);
    assign wr_en = (ready && !flush) ? pick : '0;

    a_r8_free_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en & busy) == '0);
    a_r2_all_lanes_placed: assert property (@(posedge clk) disable iff (rst)
        (ready && !flush) |-> ($countones(wr_en) == $countones(req)));
    a_r8_none_on_stall: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (wr_en == '0));
endmodule

// File: rtl/rsp_select.sv
module rsp_select #(
    parameter int N_ENT = 20,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_ENT-1:0] cand,
    input  logic             en,
    output logic [N_ENT-1:0] gnt,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    logic [N_ENT-1:0] first;
    logic             any;

    always_comb begin
        first = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (cand[i] && !any) begin
                first[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end

    assign valid = any & en;
    assign gnt   = en ? first : '0;

    a_r7_one_per_unit: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        ((gnt - 1'b1) & cand & {N_ENT{valid}}) == '0);
    a_r3_grant_needs_unit: assert property (@(posedge clk) disable iff (rst)
        !en |-> (gnt == '0));
endmodule

// File: rtl/rsp_pool.sv
module rsp_pool
    import rsp_pkg::*;
#(
    parameter int N_ENT  = 20,
    parameter int DISP_W = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           flush,
    input  logic [DISP_W-1:0]              disp_valid,
    input  logic [DISP_W-1:0][OP_W-1:0]    disp_op,
    input  logic [DISP_W-1:0][FU_W-1:0]    disp_fu,
    input  logic [DISP_W-1:0][TAG_W-1:0]   disp_dst,
    input  logic [DISP_W-1:0][TAG_W-1:0]   disp_a_tag,
    input  logic [DISP_W-1:0][DATA_W-1:0]  disp_a_data,
    input  logic [DISP_W-1:0]              disp_a_vld,
    input  logic [DISP_W-1:0][TAG_W-1:0]   disp_b_tag,
    input  logic [DISP_W-1:0][DATA_W-1:0]  disp_b_data,
    input  logic [DISP_W-1:0]              disp_b_vld,
    output logic                           disp_ready,
    input  logic                           bc_valid,
    input  logic [TAG_W-1:0]               bc_tag,
    input  logic [DATA_W-1:0]              bc_data,
    input  logic [N_FU-1:0]                fu_free,
    output logic [N_FU-1:0]                iss_valid,
    output logic [N_FU-1:0][OP_W-1:0]      iss_op,
    output logic [N_FU-1:0][TAG_W-1:0]     iss_dst,
    output logic [N_FU-1:0][DATA_W-1:0]    iss_a,
    output logic [N_FU-1:0][DATA_W-1:0]    iss_b
);
    localparam int LANE_W = (DISP_W > 1) ? $clog2(DISP_W) : 1;
    localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    cdb_t              bc;
    slot_t             lane_slot [DISP_W];
    slot_t             slot_q    [N_ENT];
    logic [N_ENT-1:0]  busy;
    logic [N_ENT-1:0]  wr_en;
    logic [N_ENT-1:0]  clr;
    logic [LANE_W-1:0] lane_sel  [N_ENT];
    logic [N_FU-1:0][N_ENT-1:0] cand;
    logic [N_FU-1:0][N_ENT-1:0] gnt;
    logic [IDX_W-1:0]  sel_idx   [N_FU];

    assign bc = '{vld: bc_valid, tag: bc_tag, data: bc_data};

    always_comb begin
        for (int l = 0; l < DISP_W; l++) begin
            lane_slot[l].op  = disp_op[l];
            lane_slot[l].fu  = disp_fu[l];
            lane_slot[l].dst = disp_dst[l];
            lane_slot[l].a   = '{tag: disp_a_tag[l], data: disp_a_data[l], vld: disp_a_vld[l]};
            lane_slot[l].b   = '{tag: disp_b_tag[l], data: disp_b_data[l], vld: disp_b_vld[l]};
        end
    end

    rsp_alloc #(.N_ENT(N_ENT), .DISP_W(DISP_W)) u_alloc (
        .clk(clk), .rst(rst), .flush(flush), .busy(busy), .req(disp_valid),
        .ready(disp_ready), .wr_en(wr_en), .lane_sel(lane_sel)
    );

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        rsp_entry u_ent (
            .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en[i]),
            .wr_slot(lane_slot[lane_sel[i]]), .bc(bc), .clr(clr[i]),
            .busy(busy[i]), .slot(slot_q[i])
        );
        for (genvar f = 0; f < N_FU; f++) begin : g_cand
            assign cand[f][i] = busy[i] && slot_ready(slot_q[i])
                                && (slot_q[i].fu == FU_W'(f));
        end
    end

    for (genvar f = 0; f < N_FU; f++) begin : g_fu
        rsp_select #(.N_ENT(N_ENT)) u_sel (
            .clk(clk), .rst(rst), .cand(cand[f]), .en(fu_free[f]),
            .gnt(gnt[f]), .idx(sel_idx[f]), .valid(iss_valid[f])
        );
        assign iss_op[f]  = slot_q[sel_idx[f]].op;
        assign iss_dst[f] = slot_q[sel_idx[f]].dst;
        assign iss_a[f]   = slot_q[sel_idx[f]].a.data;
        assign iss_b[f]   = slot_q[sel_idx[f]].b.data;
    end

    always_comb begin
        clr = '0;
        for (int f = 0; f < N_FU; f++) clr = clr | gnt[f];
    end

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (busy == '0));
    a_r3_issue_only_free_unit: assert property (@(posedge clk) disable iff (rst)
        (iss_valid & ~fu_free) == '0);
endmodule

// File: tb/sim_rsp_pool.sv
`timescale 1ns/1ps
module sim_rsp_pool;
    import rsp_pkg::*;
    localparam int NE = 20;
    localparam int DW = 3;

    logic clk = 0, rst = 1, flush = 0;
    logic [DW-1:0] disp_valid = 0;
    logic [DW-1:0][OP_W-1:0]   disp_op = 0;
    logic [DW-1:0][FU_W-1:0]   disp_fu = 0;
    logic [DW-1:0][TAG_W-1:0]  disp_dst = 0, disp_a_tag = 0, disp_b_tag = 0;
    logic [DW-1:0][DATA_W-1:0] disp_a_data = 0, disp_b_data = 0;
    logic [DW-1:0] disp_a_vld = 0, disp_b_vld = 0;
    logic disp_ready;
    logic bc_valid = 0;
    logic [TAG_W-1:0] bc_tag = 0;
    logic [DATA_W-1:0] bc_data = 0;
    logic [N_FU-1:0] fu_free = 0;
    logic [N_FU-1:0] iss_valid;
    logic [N_FU-1:0][OP_W-1:0] iss_op;
    logic [N_FU-1:0][TAG_W-1:0] iss_dst;
    logic [N_FU-1:0][DATA_W-1:0] iss_a, iss_b;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rsp_pool #(.N_ENT(NE), .DISP_W(DW)) u0 (.*);

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic clear_in();
        disp_valid = 0; disp_a_vld = 0; disp_b_vld = 0;
        bc_valid = 0; flush = 0;
    endtask

    task automatic lane(int l, int fu, int dst, int at, int ad, bit av, int bd);
        disp_valid[l]  = 1;
        disp_op[l]     = OP_W'(dst + 1);
        disp_fu[l]     = FU_W'(fu);
        disp_dst[l]    = TAG_W'(dst);
        disp_a_tag[l]  = TAG_W'(at);
        disp_a_data[l] = DATA_W'(ad);
        disp_a_vld[l]  = av;
        disp_b_tag[l]  = '0;
        disp_b_data[l] = DATA_W'(bd);
        disp_b_vld[l]  = 1;
    endtask

    task automatic expect_iss(int f, int dst, int a, int b, string req);
        #1;
        chk(iss_valid[f] == 1'b1, req, int'(iss_valid[f]), 1);
        chk(iss_dst[f] == TAG_W'(dst), req, int'(iss_dst[f]), dst);
        chk(iss_a[f] == DATA_W'(a), req, int'(iss_a[f]), a);
        chk(iss_b[f] == DATA_W'(b), req, int'(iss_b[f]), b);
    endtask

    task automatic expect_none(int f, string req);
        #1;
        chk(iss_valid[f] == 1'b0, req, int'(iss_valid[f]), 0);
    endtask

    task automatic t_reset();
        fu_free = '1; #1;
        chk(iss_valid == '0, "R1 no issue", int'(iss_valid), 0);
        disp_valid = '1; #1;
        chk(disp_ready == 1'b1, "R1 ready", int'(disp_ready), 1);
        disp_valid = 0; fu_free = 0;
    endtask

    task automatic t_ordered_single_unit();
        lane(0, 0, 1, 0, 11, 1, 21);
        lane(1, 0, 2, 0, 12, 1, 22);
        lane(2, 0, 3, 0, 13, 1, 23);
        #1 chk(disp_ready == 1'b1, "R2 accept", int'(disp_ready), 1);
        tick(); clear_in();
        fu_free[0] = 1;
        expect_iss(0, 1, 11, 21, "R2 R7 slot0 first");
        tick(); expect_iss(0, 2, 12, 22, "R7 slot1 next");
        tick(); expect_iss(0, 3, 13, 23, "R7 slot2 last");
        tick(); expect_none(0, "R9 drained");
        fu_free = 0;
    endtask

    task automatic t_wait_operand_and_unit();
        fu_free = '1;
        lane(0, 1, 10, 5, 0, 0, 33);
        tick(); clear_in();
        expect_none(1, "R3 missing operand held");
        bc_valid = 1; bc_tag = 5; bc_data = 16'hAAAA;
        tick(); bc_valid = 0;
        expect_iss(1, 10, 16'hAAAA, 33, "R4 wakeup capture");
        tick(); expect_none(1, "R9 wakeup entry gone");
        fu_free = 0;
        lane(0, 2, 11, 0, 7, 1, 8);
        tick(); clear_in();
        expect_none(2, "R3 unit busy held");
        tick(); expect_none(2, "R3 unit busy still held");
        fu_free[2] = 1;
        expect_iss(2, 11, 7, 8, "R3 issue when unit free");
        tick(); fu_free = 0;
    endtask

    task automatic t_same_cycle_capture();
        lane(0, 0, 12, 7, 0, 0, 44);
        bc_valid = 1; bc_tag = 7; bc_data = 16'h5A5A;
        tick(); clear_in();
        fu_free[0] = 1;
        expect_iss(0, 12, 16'h5A5A, 44, "R5 same-cycle capture");
        tick(); fu_free = 0;
    endtask

    task automatic t_out_of_order();
        lane(0, 0, 20, 9, 0, 0, 1);
        lane(1, 0, 21, 0, 2, 1, 3);
        tick(); clear_in();
        fu_free[0] = 1;
        expect_iss(0, 21, 2, 3, "R6 younger first");
        tick(); expect_none(0, "R6 older waits");
        bc_valid = 1; bc_tag = 9; bc_data = 99;
        tick(); bc_valid = 0;
        expect_iss(0, 20, 99, 1, "R6 older after wakeup");
        tick(); fu_free = 0;
    endtask

    task automatic t_parallel_units();
        lane(0, 2, 30, 0, 1, 1, 2);
        lane(1, 1, 31, 0, 3, 1, 4);
        lane(2, 0, 32, 0, 5, 1, 6);
        tick(); clear_in();
        fu_free = '1;
        expect_iss(0, 32, 5, 6, "R7 unit0 parallel");
        expect_iss(1, 31, 3, 4, "R7 unit1 parallel");
        expect_iss(2, 30, 1, 2, "R7 unit2 parallel");
        tick(); fu_free = 0;
    endtask

    task automatic t_stall_and_reuse();
        int cnt = 0, bad = 0;
        for (int c = 0; c < 6; c++) begin
            for (int l = 0; l < 3; l++) lane(l, 0, 3*c + l, 0, 1, 1, 1);
            tick();
        end
        for (int l = 0; l < 3; l++) lane(l, 0, 60 + l, 0, 1, 1, 1);
        #1 chk(disp_ready == 1'b0, "R8 stall 3 into 2", int'(disp_ready), 0);
        tick(); clear_in();
        lane(0, 0, 18, 0, 1, 1, 1);
        lane(1, 0, 19, 0, 1, 1, 1);
        #1 chk(disp_ready == 1'b1, "R8 2 into 2", int'(disp_ready), 1);
        tick(); clear_in();
        lane(0, 0, 61, 0, 1, 1, 1);
        #1 chk(disp_ready == 1'b0, "R8 full pool", int'(disp_ready), 0);
        tick(); clear_in();
        fu_free[0] = 1;
        tick(); fu_free = 0;
        lane(0, 0, 50, 0, 1, 1, 1);
        #1 chk(disp_ready == 1'b1, "R9 slot reused next cycle", int'(disp_ready), 1);
        tick(); clear_in();
        fu_free[0] = 1;
        for (int k = 0; k < 30; k++) begin
            #1;
            if (iss_valid[0]) begin
                cnt++;
                if (iss_dst[0] >= 60) bad++;
            end
            tick();
        end
        fu_free = 0;
        chk(cnt == 20, "R8 R9 drain count", cnt, 20);
        chk(bad == 0, "R8 stalled lanes not written", bad, 0);
    endtask

    task automatic t_flush();
        lane(0, 0, 40, 0, 1, 1, 1);
        lane(1, 1, 41, 0, 1, 1, 1);
        tick(); clear_in();
        lane(0, 2, 42, 0, 1, 1, 1);
        flush = 1;
        tick(); clear_in();
        fu_free = '1; #1;
        chk(iss_valid == '0, "R10 flush empties", int'(iss_valid), 0);
        disp_valid = '1; #1;
        chk(disp_ready == 1'b1, "R10 all free", int'(disp_ready), 1);
        disp_valid = 0; fu_free = 0;
    endtask

    task automatic t_hold_present();
        lane(0, 1, 45, 4, 16'h1111, 1, 2);
        tick(); clear_in();
        bc_valid = 1; bc_tag = 4; bc_data = 16'h2222;
        tick(); bc_valid = 0;
        fu_free[1] = 1;
        expect_iss(1, 45, 16'h1111, 2, "R11 present operand kept");
        tick(); fu_free = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        tick();
        t_reset();
        t_ordered_single_unit();
        t_wait_operand_and_unit();
        t_same_cycle_capture();
        t_out_of_order();
        t_parallel_units();
        t_stall_and_reuse();
        t_flush();
        t_hold_present();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule